// File: doc/BRIEF.md
# PCM Transmit Timeslot Serializer

This block turns payload bytes into a serial PCM transmit stream for one link in T1 or E1 format. A byte source, such as the read port of a cell buffer, answers a one-cycle request with a byte. The block places that byte in the next payload timeslot and shifts it out MSB first. Timeslots that carry no payload, and the T1 framing bit, are sent as all ones. The outgoing bit clock comes from outside the block. It is oversampled by the block's system clock, and every active edge of it advances the stream by one bit.

The frame sync has two modes. As the master, the block drives a pulse one bit period wide at the first bit of every frame. As a slave, it takes the sync from outside, aligns its frame counter to each received pulse, and sets a sticky error when a pulse comes at any position other than the expected frame start. In generic PCM mode the active edge of the bit clock and the sync polarity can each be inverted. In 2.048 Mb/s bus mode both stay fixed. When the block is disabled it drops its output enables so that the pins float.

Top module: `pcm_tx_serializer`

## Requirements
- R1: A frame is 256 bits (32 timeslots of 8 bits) in E1 and in bus mode. In generic-mode T1 a frame is 193 bits: one framing bit, sent as 1, followed by 24 timeslots.
- R2: When sync is master, the active level of `sync_out` is present during position 0 of each frame and at no other position. `sync_oe` is high while the block is enabled.
- R3: In E1, timeslots 1 to 15 and 17 to 31 carry payload. Timeslots 0 and 16 send 8'hFF.
- R4: In T1 bus mode with `cfg_sparse`=0, timeslots 0 to 23 carry payload and the remaining timeslots send 8'hFF.
- R5: In T1 bus mode with `cfg_sparse`=1, payload goes in every timeslot whose index is not a multiple of 4.
- R6: With `cfg_rsv_last`=1 in T1, the last payload timeslot of the layout in use (slot 23 in the dense or generic layout, slot 31 in the sparse one) sends 8'hFF and requests no byte.
- R7: Each payload byte is sent MSB first. `byte_req` is high for exactly one system clock, raised at the start of the bit just before the first bit of a payload timeslot. `byte_in` is captured on the next clock edge. The holding byte is 8'hFF after reset.
- R8: In generic mode, `cfg_clk_inv`=1 makes the falling edge of `bclk` the active edge, and `cfg_sync_inv`=1 makes the sync active low. In bus mode both settings are ignored.
- R9: When sync is slave, a sampled sync pulse moves the frame position to 0. Once a first pulse has been seen, a pulse at any other position than the expected frame start sets `sync_err`, which stays set until reset.
- R10: With `en`=0, `ser_oe` and `sync_oe` are low from the next clock, no byte is requested, and the frame position is reset, so the first active edge after re-enabling starts frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable for the transmit path |
| cfg_t1 | input | 1 | 1 selects T1, 0 selects E1 |
| cfg_bus | input | 1 | 1 selects the 2.048 Mb/s bus mode, 0 selects generic PCM |
| cfg_sparse | input | 1 | T1 bus layout: 1 uses three of every four timeslots |
| cfg_rsv_last | input | 1 | Keep the last T1 payload timeslot free |
| cfg_clk_inv | input | 1 | Generic mode: falling bit clock edge is active |
| cfg_sync_inv | input | 1 | Generic mode: sync is active low |
| cfg_sync_master | input | 1 | 1 drives sync, 0 monitors sync |
| bclk | input | 1 | External transmit bit clock |
| sync_in | input | 1 | External frame sync (slave mode) |
| byte_in | input | SLOT_BITS | Payload byte from the byte source |
| byte_req | output | 1 | One-cycle request for the next payload byte |
| ser_data | output | 1 | Serial data |
| ser_oe | output | 1 | Output enable of serial data |
| sync_out | output | 1 | Generated frame sync |
| sync_oe | output | 1 | Output enable of frame sync |
| sync_err | output | 1 | Sticky flag for a sync at an unexpected position |

## Verification
Each input passes through a single synchronizer register before the bit clock edge is detected. Every serial output, sync output, error flag and byte request for a bit therefore changes on the second system clock edge after the bench moves `bclk` to its active level. The bench drives at a falling clock edge, waits two rising edges and samples at the falling edge that follows, so it reads each bit's outputs exactly once while they are stable. Output enables follow `en` one edge later and are sampled at the next falling edge. A byte offered in reply to a request is driven at that same sampling point, which places it before the capture edge.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef struct packed {
    logic t1;
    logic bus;
    logic sparse;
    logic rsv;
    logic clk_inv;
    logic sync_inv;
    logic master;
  } cfg_t;

  typedef struct packed {
    logic start;
    logic pay;
  } slot_info_t;
endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic sync_in,
  input  logic clk_inv,
  input  logic sync_inv,
  output logic tick,
  output logic sync_hit
);
  logic b1, b2, s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      b1 <= 1'b0;
      b2 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      b1 <= bclk ^ clk_inv;
      b2 <= b1;
      s1 <= sync_in ^ sync_inv;
    end
  end

  assign tick     = b1 & ~b2;
  assign sync_hit = s1;

  // R8: an active edge yields a single tick
  p_tick_single_r8: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer import pcm_tx_pkg::*; #(
  parameter int SLOT_BITS   = 8,
  parameter int FRAME_SLOTS = 32,
  parameter int T1_SLOTS    = 24,
  parameter int GROUP       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  cfg_t cfg,
  input  logic tick,
  input  logic sync_hit,
  output logic ld,
  output logic ld_pay,
  output logic req,
  output logic sync_out,
  output logic sync_err
);
  localparam int BUS_LEN = FRAME_SLOTS * SLOT_BITS;
  localparam int T1G_LEN = T1_SLOTS * SLOT_BITS + 1;
  localparam int POS_W   = $clog2(BUS_LEN);

  logic [POS_W-1:0] pos, last, advance, pos_nxt, pos_n2;
  logic             locked, realign, sinv;
  slot_info_t       info_n, info_n2;

  function automatic slot_info_t decode(input logic [POS_W-1:0] p, input cfg_t c);
    slot_info_t r;
    int idx, slot;
    r = '0;
    if (c.t1 && !c.bus) begin
      if (p == '0) begin
        r.start = 1'b1;
        r.pay   = 1'b0;
      end else begin
        idx     = int'(p) - 1;
        slot    = idx / SLOT_BITS;
        r.start = (idx % SLOT_BITS) == 0;
        r.pay   = !(c.rsv && slot == T1_SLOTS - 1);
      end
    end else begin
      idx     = int'(p);
      slot    = idx / SLOT_BITS;
      r.start = (idx % SLOT_BITS) == 0;
      if (!c.t1)
        r.pay = (slot != 0) && (slot != FRAME_SLOTS / 2);
      else if (!c.sparse)
        r.pay = slot < (c.rsv ? T1_SLOTS - 1 : T1_SLOTS);
      else
        r.pay = ((slot % GROUP) != 0) && !(c.rsv && slot == FRAME_SLOTS - 1);
    end
    return r;
  endfunction

  always_comb begin
    sinv    = cfg.sync_inv & ~cfg.bus;
    last    = (cfg.t1 && !cfg.bus) ? POS_W'(T1G_LEN - 1) : POS_W'(BUS_LEN - 1);
    advance = (pos == last) ? '0 : pos + POS_W'(1);
    realign = !cfg.master && sync_hit;
    pos_nxt = realign ? '0 : advance;
    pos_n2  = (pos_nxt == last) ? '0 : pos_nxt + POS_W'(1);
    info_n  = decode(pos_nxt, cfg);
    info_n2 = decode(pos_n2, cfg);
  end

  assign ld     = info_n.start;
  assign ld_pay = info_n.pay;
  assign req    = info_n2.start & info_n2.pay;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= last;
      locked   <= 1'b0;
      sync_out <= sinv;
      sync_err <= 1'b0;
    end else if (!en) begin
      pos      <= last;
      locked   <= 1'b0;
      sync_out <= sinv;
    end else if (tick) begin
      pos      <= pos_nxt;
      locked   <= locked | realign;
      sync_out <= (cfg.master && pos_nxt == '0) ^ sinv;
      if (realign && locked && advance != '0)
        sync_err <= 1'b1;
    end
  end

  // R1: position never leaves the frame
  p_pos_range_r1: assert property (@(posedge clk) disable iff (rst) pos <= last);
  // R2: an active generated sync only at frame start
  p_sync_start_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg.master && (sync_out ^ sinv)) |-> pos == '0);
  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst) sync_err |=> sync_err);
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 tick,
  input  logic                 ld,
  input  logic                 ld_pay,
  input  logic                 req,
  input  logic [SLOT_BITS-1:0] byte_in,
  output logic                 byte_req,
  output logic                 ser_data
);
  logic [SLOT_BITS-1:0] shreg, hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '1;
      hold     <= '1;
      byte_req <= 1'b0;
    end else begin
      byte_req <= en && tick && req;
      if (byte_req)
        hold <= byte_in;
      if (!en)
        shreg <= '1;
      else if (tick) begin
        if (ld)
          shreg <= ld_pay ? hold : '1;
        else
          shreg <= {shreg[SLOT_BITS-2:0], 1'b1};
      end
    end
  end

  assign ser_data = shreg[SLOT_BITS-1];

  // R7: request lasts one system clock
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst) byte_req |=> !byte_req);
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer import pcm_tx_pkg::*; #(
  parameter int SLOT_BITS   = 8,
  parameter int FRAME_SLOTS = 32,
  parameter int T1_SLOTS    = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 cfg_t1,
  input  logic                 cfg_bus,
  input  logic                 cfg_sparse,
  input  logic                 cfg_rsv_last,
  input  logic                 cfg_clk_inv,
  input  logic                 cfg_sync_inv,
  input  logic                 cfg_sync_master,
  input  logic                 bclk,
  input  logic                 sync_in,
  input  logic [SLOT_BITS-1:0] byte_in,
  output logic                 byte_req,
  output logic                 ser_data,
  output logic                 ser_oe,
  output logic                 sync_out,
  output logic                 sync_oe,
  output logic                 sync_err
);
  cfg_t cfg;
  logic tick, sync_hit, ld, ld_pay, req;

  assign cfg = '{t1: cfg_t1, bus: cfg_bus, sparse: cfg_sparse, rsv: cfg_rsv_last,
                 clk_inv: cfg_clk_inv, sync_inv: cfg_sync_inv, master: cfg_sync_master};

  pcm_tx_edge u_edge (
    .clk(clk), .rst(rst), .bclk(bclk), .sync_in(sync_in),
    .clk_inv(cfg_clk_inv & ~cfg_bus), .sync_inv(cfg_sync_inv & ~cfg_bus),
    .tick(tick), .sync_hit(sync_hit)
  );

  pcm_tx_framer #(.SLOT_BITS(SLOT_BITS), .FRAME_SLOTS(FRAME_SLOTS), .T1_SLOTS(T1_SLOTS)) u_framer (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg), .tick(tick), .sync_hit(sync_hit),
    .ld(ld), .ld_pay(ld_pay), .req(req), .sync_out(sync_out), .sync_err(sync_err)
  );

  pcm_tx_shifter #(.SLOT_BITS(SLOT_BITS)) u_shift (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .ld(ld), .ld_pay(ld_pay), .req(req),
    .byte_in(byte_in), .byte_req(byte_req), .ser_data(ser_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_oe  <= 1'b0;
      sync_oe <= 1'b0;
    end else begin
      ser_oe  <= en;
      sync_oe <= en & cfg_sync_master;
    end
  end

  // R10: disabling floats the outputs on the next clock
  p_oe_off_r10: assert property (@(posedge clk) disable iff (rst) !en |=> (!ser_oe && !sync_oe));
  // R10: no request while outputs are floated
  p_req_enabled_r10: assert property (@(posedge clk) disable iff (rst) byte_req |-> ser_oe);
endmodule

// File: tb/sim_pcm_tx_serializer.sv
module sim_pcm_tx_serializer;
  logic clk = 0, rst = 1, en = 0;
  logic t1 = 0, bus = 0, sparse = 0, rsv = 0, cinv = 0, sinv = 0, master = 1;
  logic bclk = 0, sync_in = 0;
  logic [7:0] byte_in = 8'h00;
  logic byte_req, ser_data, ser_oe, sync_out, sync_oe, sync_err;

  int checks = 0, errs = 0;
  int bp = 0;
  bit started = 0, locked = 0, err_exp = 0;
  logic [7:0] given = 8'hFF, cur = 8'hFF;
  string dtag = "R3", stag = "R2";

  always #10 clk = ~clk;

  pcm_tx_serializer u0 (
    .clk(clk), .rst(rst), .en(en), .cfg_t1(t1), .cfg_bus(bus), .cfg_sparse(sparse),
    .cfg_rsv_last(rsv), .cfg_clk_inv(cinv), .cfg_sync_inv(sinv), .cfg_sync_master(master),
    .bclk(bclk), .sync_in(sync_in), .byte_in(byte_in), .byte_req(byte_req),
    .ser_data(ser_data), .ser_oe(ser_oe), .sync_out(sync_out), .sync_oe(sync_oe),
    .sync_err(sync_err)
  );

  function automatic bit t1g(); return t1 && !bus; endfunction
  function automatic logic idle_lvl(); return cinv && !bus; endfunction
  function automatic logic sinv_eff(); return sinv && !bus; endfunction
  function automatic int m_len(); return t1g() ? 193 : 256; endfunction
  function automatic bit m_start(int p);
    if (t1g()) return (p == 0) || ((p - 1) % 8 == 0);
    return (p % 8) == 0;
  endfunction
  function automatic bit m_pay(int p);
    int s;
    if (t1g()) begin
      if (p == 0) return 0;
      s = (p - 1) / 8;
      return !(rsv && s == 23);
    end
    s = p / 8;
    if (!t1) return s != 0 && s != 16;
    if (!sparse) return s < (rsv ? 23 : 24);
    return (s % 4 != 0) && !(rsv && s == 31);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d)", tag, act, exp, bp);
    end
  endtask

  task automatic bit_step(input bit sy);
    int nxt, n2;
    bit exp_req;
    bclk = ~idle_lvl();
    sync_in = sy ^ sinv_eff();
    nxt = started ? ((bp + 1 == m_len()) ? 0 : bp + 1) : 0;
    if (!master && sy) begin
      if (locked && nxt != 0) err_exp = 1;
      locked = 1;
      nxt = 0;
    end
    bp = nxt;
    started = 1;
    if (m_start(bp)) cur = m_pay(bp) ? given : 8'hFF;
    else cur = {cur[6:0], 1'b1};
    n2 = (bp + 1 == m_len()) ? 0 : bp + 1;
    exp_req = m_start(n2) && m_pay(n2);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(ser_data === cur[7], dtag, ser_data, cur[7]);
    chk(byte_req === exp_req, "R7", byte_req, exp_req);
    if (master) chk(sync_out === ((bp == 0) ^ sinv_eff()), stag, sync_out, (bp == 0) ^ sinv_eff());
    else chk(sync_err === err_exp, "R9", sync_err, err_exp);
    if (byte_req) begin
      given = 8'($urandom);
      byte_in = given;
    end
    bclk = idle_lvl();
    sync_in = sinv_eff();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic setup(input bit a_t1, input bit a_bus, input bit a_sp, input bit a_rsv,
                       input bit a_ci, input bit a_si, input bit a_m, input string d, input string s);
    @(negedge clk);
    rst = 1; en = 0;
    t1 = a_t1; bus = a_bus; sparse = a_sp; rsv = a_rsv; cinv = a_ci; sinv = a_si; master = a_m;
    dtag = d; stag = s;
    bclk = idle_lvl(); sync_in = sinv_eff();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ser_oe === 1'b0 && sync_oe === 1'b0, "R10", ser_oe, 0);
    chk(byte_req === 1'b0 && sync_err === 1'b0, "R9", sync_err, 0);
    started = 0; locked = 0; err_exp = 0; given = 8'hFF; cur = 8'hFF;
    en = 1;
    @(negedge clk);
    chk(ser_oe === 1'b1, "R10", ser_oe, 1);
    chk(sync_oe === a_m, "R2", sync_oe, a_m);
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n * m_len() + 5; i++) bit_step(0);
  endtask

  initial begin
    int k;
    void'($urandom(32'd2024));
    setup(0, 0, 0, 0, 0, 0, 1, "R3", "R2"); run_frames(2);
    setup(0, 0, 0, 0, 1, 1, 1, "R8", "R2"); run_frames(2);
    setup(1, 0, 0, 0, 0, 0, 1, "R1", "R1"); run_frames(2);
    setup(1, 0, 0, 1, 0, 0, 1, "R6", "R1"); run_frames(2);
    setup(1, 1, 0, 0, 1, 1, 1, "R4", "R8"); run_frames(2);
    setup(1, 1, 1, 0, 0, 0, 1, "R5", "R2"); run_frames(2);
    setup(1, 1, 1, 1, 0, 0, 1, "R6", "R2"); run_frames(1);
    setup(1, 1, 0, 1, 0, 0, 1, "R6", "R2"); run_frames(1);
    setup(0, 1, 0, 0, 0, 0, 1, "R1", "R1"); run_frames(1);

    // R9: slave sync, lock, correct period, then a misplaced pulse
    setup(0, 0, 0, 0, 0, 0, 0, "R3", "R9");
    for (int i = 0; i < 3; i++) bit_step(0);
    bit_step(1);
    chk(sync_err === 1'b0, "R9", sync_err, 0);
    for (int i = 0; i < 255; i++) bit_step(0);
    bit_step(1);
    chk(sync_err === 1'b0, "R9", sync_err, 0);
    k = 20 + int'($urandom % 200);
    for (int i = 0; i < k; i++) bit_step(0);
    bit_step(1);
    chk(sync_err === 1'b1, "R9", sync_err, 1);
    for (int i = 0; i < 300; i++) bit_step(0);
    chk(sync_err === 1'b1, "R9", sync_err, 1);

    // R10: disable mid-frame, then re-enable at frame start
    setup(0, 0, 0, 0, 0, 0, 1, "R3", "R2");
    for (int i = 0; i < 70; i++) bit_step(0);
    en = 0;
    @(negedge clk);
    chk(ser_oe === 1'b0 && sync_oe === 1'b0, "R10", ser_oe, 0);
    for (int i = 0; i < 20; i++) begin
      bclk = 1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(byte_req === 1'b0, "R10", byte_req, 0);
      bclk = 0;
      @(posedge clk); @(posedge clk); @(negedge clk);
    end
    en = 1;
    @(negedge clk);
    started = 0;
    for (int i = 0; i < 300; i++) bit_step(0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired at pos %0d", bp);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule